// File: doc/BRIEF.md
# Card Socket Status Interrupt Register

This block is a read-only status word for a removable-card socket. It brings the socket's detect, voltage-sense, write-protect and ready pins into the clock domain and shows their current levels. It also shows the two supply-enable levels that the rest of the chip drives toward the socket. Three sticky flags record level changes on the detect pair, on write protect and on ready.

A host selects the register and pulses a read strobe. The word it reads shows the flags as they stood before the read, and the read clears them. A flag whose mask bit is clear drives the interrupt line for as long as it stays set.

Every raw pin passes through a two-stage synchronizer. Change detection compares each synchronized sample with the one taken a cycle earlier. The comparison history is only trusted once it has been loaded with a real sample, so leaving reset never produces a change event.

Top module: `sock_status_reg`

## Requirements
- R1: Status bits [1:0] show the two active-low detect lines (bit 0 first line, bit 1 second line). Bits [3:2] show voltage sense 1 and 2, bit 4 shows write protect and bit 5 shows ready. Each is the pin level delayed by two clock edges of synchronization.
- R2: Bit 6 shows the 3 V supply-enable level and bit 7 shows the 5 V supply-enable level, each registered once. Both read 0 while in reset.
- R3: Bit 8 sets one edge after a level change on either detect line reaches the synchronized sample, and it stays set until cleared.
- R4: Bit 9 sets on a write-protect change and bit 10 sets on a ready change, with the same timing as R3. A change on voltage sense alone sets no flag.
- R5: A cycle with select and read strobe both high clears bits 10:8 at the next edge. The data returned in that cycle shows the flags before the clear.
- R6: If a change is detected in the same cycle as a clearing read, its flag is set after the edge, so the event is not lost.
- R7: The interrupt is high exactly when some flag is set and its mask bit is 0. Mask bit 0 covers bit 8, mask bit 1 covers bit 9 and mask bit 2 covers bit 10.
- R8: Bits 63:11 always read 0. The whole data word is 0 while select is low, and a read strobe without select clears nothing.
- R9: After reset all flags are 0, and no flag sets because of the sampling restarting, even when the pins sit high through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Register select |
| rd_i | input | 1 | Read strobe; clears the flags when selected |
| rdata_o | output | 64 | Status word, zero when not selected |
| cd_n_i | input | 2 | Raw active-low card-detect lines |
| vsense_i | input | 2 | Raw voltage-sense lines |
| wprot_i | input | 1 | Raw write-protect line, high means protected |
| ready_i | input | 1 | Raw ready line, high means accessible |
| en3v_i | input | 1 | 3 V supply-enable level being driven |
| en5v_i | input | 1 | 5 V supply-enable level being driven |
| irq_mask_i | input | 3 | Per-flag interrupt mask, 1 means masked |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench walks all 64 pin patterns in counting order. Each step toggles a different mix of lines and uses a mask that rotates through all eight values, so a design that folded the detect pair wrong, or that flagged voltage-sense changes, reads back a wrong flag field. It starts with every pin high through reset: a design without a primed history would raise the detect flags at once. It also lines a write-protect change up with the clearing read, where a design that lets the clear win drops the event. Finally it strobes a read without select, which a design that decodes only the strobe would wrongly clear.

// File: rtl/sock_pkg.sv
package sock_pkg;
    localparam int DATA_W   = 64;
    localparam int N_PIN    = 6;
    localparam int N_FLAG   = 3;
    localparam int N_EN     = 2;
    localparam int STAT_W   = N_PIN + N_EN + N_FLAG;
    localparam int SYNC_LEN = 2;

    // positions inside the sampled pin vector (match status bits 5:0)
    localparam int PIN_CD0 = 0;
    localparam int PIN_CD1 = 1;
    localparam int PIN_WP  = 4;
    localparam int PIN_RDY = 5;

    typedef struct packed {
        logic       rdy;
        logic       wp;
        logic [1:0] vs;
        logic [1:0] cd_n;
    } sock_pins_t;

    typedef struct packed {
        logic rdy_chg;
        logic wp_chg;
        logic cd_chg;
    } sock_flags_t;
endpackage

// File: rtl/sock_sync.sv
module sock_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         vld_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [STAGES-1:0]        vld;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = d_i;
        st_d.vld[0]  = 1'b1;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
            st_d.vld[s]  = st_q.vld[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o   = st_q.pipe[STAGES-1];
    assign vld_o = st_q.vld[STAGES-1];
endmodule

// File: rtl/sock_edge.sv
module sock_edge #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    input  logic         vld_i,
    output logic [W-1:0] diff_o
);
    typedef struct packed {
        logic [W-1:0] hist;
        logic         hist_vld;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.hist     = smp_i;
        st_d.hist_vld = st_q.hist_vld | vld_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // compare only once the history holds a genuine sample
    assign diff_o = st_q.hist_vld ? (smp_i ^ st_q.hist) : '0;

    AST_DIFF_NEEDS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_o != '0) |-> !$stable(smp_i)) else $error("diff without input move"); // R9
endmodule

// File: rtl/sock_flags.sv
module sock_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a set arriving with the clear wins so no event is dropped
        st_d.flags = (st_q.flags & ~{N{clr_i}}) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |(st_q.flags & ~mask_i);

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !clr_i) |=> flags_o[i]) else $error("flag dropped"); // R3
        AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i[i]) |=> !flags_o[i]) else $error("flag not cleared"); // R5
        AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && set_i[i]) |=> flags_o[i]) else $error("coincident event lost"); // R6
        AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_o[i]) |-> $past(set_i[i])) else $error("flag set without cause"); // R4
    end

    AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_i) |-> !irq_o) else $error("irq while fully masked"); // R7
endmodule

// File: rtl/sock_status_reg.sv
module sock_status_reg
    import sock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [1:0]        cd_n_i,
    input  logic [1:0]        vsense_i,
    input  logic              wprot_i,
    input  logic              ready_i,
    input  logic              en3v_i,
    input  logic              en5v_i,
    input  logic [N_FLAG-1:0] irq_mask_i,
    output logic              irq_o
);
    typedef struct packed {
        logic [N_EN-1:0] en;
    } top_st_t;

    top_st_t     st_d, st_q;
    sock_pins_t  raw_pins;
    logic [N_PIN-1:0]  smp;
    logic              smp_vld;
    logic [N_PIN-1:0]  diff;
    sock_flags_t       set_vec;
    logic [N_FLAG-1:0] flags;
    logic              clr;
    logic [STAT_W-1:0] stat_word;

    always_comb begin
        raw_pins.cd_n = cd_n_i;
        raw_pins.vs   = vsense_i;
        raw_pins.wp   = wprot_i;
        raw_pins.rdy  = ready_i;
    end

    sock_sync #(.W(N_PIN), .STAGES(SYNC_LEN)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_pins),
        .q_o   (smp),
        .vld_o (smp_vld)
    );

    sock_edge #(.W(N_PIN)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (smp),
        .vld_i  (smp_vld),
        .diff_o (diff)
    );

    always_comb begin
        set_vec.cd_chg  = diff[PIN_CD0] | diff[PIN_CD1];
        set_vec.wp_chg  = diff[PIN_WP];
        set_vec.rdy_chg = diff[PIN_RDY];
        clr             = sel_i & rd_i;
    end

    sock_flags #(.N(N_FLAG)) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr),
        .mask_i  (irq_mask_i),
        .flags_o (flags),
        .irq_o   (irq_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = {en5v_i, en3v_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_word = {flags, st_q.en, smp};
    assign rdata_o   = sel_i ? DATA_W'(stat_word) : '0;

    AST_DESELECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |-> (rdata_o == '0)) else $error("data leaked while deselected"); // R8
    AST_EN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i |=> (rdata_o[6] == $past(en3v_i)) || !sel_i) else $error("3V mirror wrong"); // R2
endmodule

// File: tb/sock_status_reg_tb_top.sv
module sock_status_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [63:0] rdata_o;
    logic [1:0]  cd_n_i = 2'b11;
    logic [1:0]  vsense_i = 2'b11;
    logic        wprot_i = 1'b1;
    logic        ready_i = 1'b1;
    logic        en3v_i = 1'b1;
    logic        en5v_i = 1'b1;
    logic [2:0]  irq_mask_i = 3'b000;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sock_status_reg dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_i),
        .rd_i       (rd_i),
        .rdata_o    (rdata_o),
        .cd_n_i     (cd_n_i),
        .vsense_i   (vsense_i),
        .wprot_i    (wprot_i),
        .ready_i    (ready_i),
        .en3v_i     (en3v_i),
        .en5v_i     (en5v_i),
        .irq_mask_i (irq_mask_i),
        .irq_o      (irq_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_pins(input logic [5:0] p);
        cd_n_i   = p[1:0];
        vsense_i = p[3:2];
        wprot_i  = p[4];
        ready_i  = p[5];
    endtask

    function automatic logic [63:0] word(input logic [5:0] p, input logic [1:0] en,
                                         input logic [2:0] fl);
        logic [63:0] w;
        w       = '0;
        w[5:0]  = p;
        w[7:6]  = en;
        w[10:8] = fl;
        return w;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [5:0] prev;
        logic [63:0] exp;
        prev = 6'h3F;
        sel_i = 1'b1;
        repeat (3) @(negedge clk);
        // R9 / R2: reset state with every pin high
        check(rdata_o == 64'h0, "R2 reset word", rdata_o, 64'h0);
        check(irq_o == 1'b0, "R9 reset irq", 64'(irq_o), 64'h0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        exp = word(6'h3F, 2'b11, 3'b000);
        check(rdata_o == exp, "R9 no false change after reset", rdata_o, exp);
        check(irq_o == 1'b0, "R9 no irq after reset", 64'(irq_o), 64'h0);

        // R1 R3 R4 R5 R7 R8: sweep every pin pattern
        for (int i = 0; i < 64; i++) begin
            logic [5:0] pat;
            logic [5:0] d;
            logic [2:0] fl;
            logic [1:0] en;
            logic [2:0] msk;
            pat = 6'(i);
            en  = {pat[2], pat[0] ^ pat[3]};
            msk = 3'(i % 8);
            put_pins(pat);
            en3v_i = en[0];
            en5v_i = en[1];
            irq_mask_i = msk;
            repeat (3) @(posedge clk);
            @(negedge clk);
            d  = prev ^ pat;
            fl = {d[5], d[4], d[1] | d[0]};
            check(irq_o == |(fl & ~msk), "R7 masked interrupt", 64'(irq_o),
                  64'(|(fl & ~msk)));
            rd_i = 1'b1;
            exp  = word(pat, en, fl);
            check(rdata_o == exp, "R1 R3 R4 R5 R8 word before clear", rdata_o, exp);
            @(negedge clk);
            rd_i = 1'b0;
            exp  = word(pat, en, 3'b000);
            check(rdata_o == exp, "R5 flags cleared by read", rdata_o, exp);
            prev = pat;
        end

        // R6: write-protect change lands in the clearing cycle
        irq_mask_i = 3'b000;
        put_pins(prev ^ 6'h10);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rd_i = 1'b1;
        check(rdata_o[10:8] == 3'b000, "R6 pre-clear flags", 64'(rdata_o[10:8]), 64'h0);
        @(negedge clk);
        rd_i = 1'b0;
        check(rdata_o[10:8] == 3'b010, "R6 coincident change kept", 64'(rdata_o[10:8]),
              64'h2);
        check(irq_o == 1'b1, "R7 irq from kept flag", 64'(irq_o), 64'h1);
        prev = prev ^ 6'h10;

        // R8: deselected reads return zero and clear nothing
        sel_i = 1'b0;
        rd_i  = 1'b1;
        @(negedge clk);
        check(rdata_o == 64'h0, "R8 deselected word", rdata_o, 64'h0);
        rd_i = 1'b0;
        sel_i = 1'b1;
        @(negedge clk);
        check(rdata_o[10:8] == 3'b010, "R8 strobe without select kept flag",
              64'(rdata_o[10:8]), 64'h2);
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        check(rdata_o[10:8] == 3'b000, "R5 final clear", 64'(rdata_o[10:8]), 64'h0);
        check(irq_o == 1'b0, "R7 irq drops after clear", 64'(irq_o), 64'h0);

        // R4: voltage sense alone sets nothing
        put_pins(prev ^ 6'h0C);
        repeat (4) @(negedge clk);
        exp = word(prev ^ 6'h0C, {en5v_i, en3v_i}, 3'b000);
        check(rdata_o == exp, "R4 voltage sense sets no flag", rdata_o, exp);

        done = 1'b1;
        summary();
    end
endmodule